// File: doc/BRIEF.md
# Four-Way Distributed Bus Arbitration Cluster

This block holds one arbitration controller per device on a synchronous shared bus. No central arbiter exists. Every controller watches the bus-request lines of all devices and decides on its own, at each rising clock edge, whether it owns the bus in the next cycle. Each bus transaction takes exactly one cycle. A device that has just owned the bus may not own it again in the following cycle.

Priority is fixed by position. Device index 0 has priority 1 and device index 3 has priority 4, which is the highest. Each controller is a clocked Moore machine with three states: idle, requesting and owning.

- A device tells its controller that it wants the bus through a plain level input.
- The controller raises its request line, holds it until it has been served, and owns the bus for one cycle.

The top-level wrapper connects the controllers in order, so that their shared behaviour, mutual exclusion among them, can be observed and checked. No data moves through the block, so it has no valid/ready interface. All pins are plain control levels with no back-pressure.

Top module: `dbus_arb_cluster`

## Requirements
- R1: While synchronous active-high `rst` is high at a rising edge, every controller enters idle, and after that edge both `bus_req` and `bus_master` read all zeros.
- R2: An idle controller whose `dev_want[i]` is high at a rising edge raises `bus_req[i]` after that edge. If `dev_want[i]` is low, the controller stays idle with `bus_req[i]` low.
- R3: A requesting controller `i` becomes owner after the next rising edge exactly when no line `bus_req[j]` with j > i is high at that edge. Bit 3 is the highest priority and bit 0 is the lowest.
- R4: Ownership (`bus_master[i]` high) lasts exactly one cycle, and `bus_req[i]` is low while `bus_master[i]` is high.
- R5: After its owning cycle, a controller returns to requesting if `dev_want[i]` is high at that edge, and to idle otherwise.
- R6: No device owns the bus in two consecutive cycles. When the highest requester has just owned the bus, the next-highest requester wins, so two devices that keep requesting take turns.
- R7: At most one bit of `bus_master` is high in any cycle.
- R8: While two higher-priority devices keep requesting, a lower-priority requester stays in requesting and never owns the bus (starvation).
- R9: Once `bus_req[i]` is high, dropping `dev_want[i]` has no effect. The request stays up until that device has owned the bus for one cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| dev_want | input | NUM_DEV | Per-device level: device wants a bus cycle |
| bus_req | output | NUM_DEV | Per-device bus-request lines, seen by all controllers |
| bus_master | output | NUM_DEV | Per-device ownership indication for the current cycle |

## Verification
A request line rises one edge after `dev_want` is sampled high in idle. Ownership follows one edge after a request is sampled with no higher request present. The release to idle or requesting comes one edge after the owning cycle. The bench drives inputs and samples outputs on the falling edge, so each expected value is read half a cycle after the rising edge that produces it. A sequence with all four devices requesting checks the turn-taking, the starvation and the one-edge-per-step drain in strict priority order.

// File: rtl/dbus_arb_pkg.sv
package dbus_arb_pkg;

  localparam int unsigned DEF_NUM_DEV = 4;

  typedef enum logic [1:0] {
    ND_IDLE  = 2'd0,
    ND_WAIT  = 2'd1,
    ND_OWN   = 2'd2
  } node_state_e;

endpackage

// File: rtl/dbus_higher_mask.sv
module dbus_higher_mask #(
  parameter int unsigned NUM_DEV = 4,
  parameter int unsigned LEVEL   = 0
) (
  input  logic [NUM_DEV-1:0] bus_req,
  output logic               higher_busy
);

  // Any request line above this controller's own position blocks it.
  always_comb begin
    higher_busy = 1'b0;
    for (int j = 0; j < NUM_DEV; j++) begin
      if (j > int'(LEVEL)) higher_busy = higher_busy | bus_req[j];
    end
  end

endmodule

// File: rtl/dbus_node.sv
module dbus_node
  import dbus_arb_pkg::*;
#(
  parameter int unsigned NUM_DEV = 4,
  parameter int unsigned LEVEL   = 0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               want,
  input  logic [NUM_DEV-1:0] bus_req,
  output logic               req_o,
  output logic               master_o
);

  node_state_e state_q, state_d;
  logic        blocked;

  dbus_higher_mask #(
    .NUM_DEV (NUM_DEV),
    .LEVEL   (LEVEL)
  ) mask_i (
    .bus_req     (bus_req),
    .higher_busy (blocked)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ND_IDLE: if (want) state_d = ND_WAIT;
      ND_WAIT: if (!blocked) state_d = ND_OWN;
      ND_OWN:  state_d = want ? ND_WAIT : ND_IDLE;
      default: state_d = ND_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= ND_IDLE;
    else     state_q <= state_d;
  end

  // Moore outputs: request line is down while owning, so a lower device
  // can claim the following cycle.
  assign req_o    = (state_q == ND_WAIT);
  assign master_o = (state_q == ND_OWN);

endmodule

// File: rtl/dbus_arb_cluster.sv
module dbus_arb_cluster #(
  parameter int unsigned NUM_DEV = dbus_arb_pkg::DEF_NUM_DEV
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_DEV-1:0] dev_want,
  output logic [NUM_DEV-1:0] bus_req,
  output logic [NUM_DEV-1:0] bus_master
);

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_node
    dbus_node #(
      .NUM_DEV (NUM_DEV),
      .LEVEL   (g)
    ) node_i (
      .clk      (clk),
      .rst      (rst),
      .want     (dev_want[g]),
      .bus_req  (bus_req),
      .req_o    (bus_req[g]),
      .master_o (bus_master[g])
    );
  end

endmodule

// File: rtl/dbus_arb_checker.sv
module dbus_arb_checker #(
  parameter int unsigned NUM_DEV = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_DEV-1:0] dev_want,
  input logic [NUM_DEV-1:0] bus_req,
  input logic [NUM_DEV-1:0] bus_master
);

  AST_ONE_OWNER: assert property (@(posedge clk) disable iff (rst)
    $onehot0(bus_master)); // R7

  AST_NO_REPEAT_OWNER: assert property (@(posedge clk) disable iff (rst)
    (|bus_master) |=> ((bus_master & $past(bus_master)) == '0)); // R6

  for (genvar g = 0; g < NUM_DEV; g++) begin : g_chk
    AST_REQ_DOWN_WHILE_OWNER: assert property (@(posedge clk) disable iff (rst)
      bus_master[g] |-> !bus_req[g]); // R4

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst)
      bus_req[g] |=> (bus_req[g] || bus_master[g])); // R9

    AST_WIN_WHEN_TOP: assert property (@(posedge clk) disable iff (rst)
      (bus_req[g] && ((bus_req >> (g + 1)) == '0)) |=> bus_master[g]); // R3

    AST_OWN_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      bus_master[g] |=> (bus_req[g] == $past(dev_want[g]))); // R5
  end

endmodule

bind dbus_arb_cluster dbus_arb_checker #(.NUM_DEV(NUM_DEV)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .dev_want   (dev_want),
  .bus_req    (bus_req),
  .bus_master (bus_master)
);

// File: tb/dbus_arb_cluster_tb_top.sv
module dbus_arb_cluster_tb_top;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [3:0] dev_want = '0;
  logic [3:0] bus_req;
  logic [3:0] bus_master;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  always #5 clk = ~clk;

  dbus_arb_cluster #(.NUM_DEV(4)) dut_i (
    .clk        (clk),
    .rst        (rst),
    .dev_want   (dev_want),
    .bus_req    (bus_req),
    .bus_master (bus_master)
  );

  task automatic check4(input string tag, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    dev_want = 4'b1111;
    step(); step();
    check4("R1 req after reset", bus_req, 4'b0000);
    check4("R1 master after reset", bus_master, 4'b0000);
    rst = 1'b0;
    dev_want = 4'b0000;
    step();
    check4("R2 idle stays low", bus_req, 4'b0000);
  endtask

  task automatic t_single();
    dev_want = 4'b0010;
    step();
    check4("R2 req raised", bus_req, 4'b0010);
    check4("R2 no master yet", bus_master, 4'b0000);
    dev_want = 4'b0000;  // dropped while requesting: ignored
    step();
    check4("R9 R3 lone requester owns", bus_master, 4'b0010);
    check4("R4 req low while owner", bus_req, 4'b0000);
    step();
    check4("R5 back to idle master", bus_master, 4'b0000);
    check4("R5 back to idle req", bus_req, 4'b0000);
  endtask

  task automatic t_contend();
    logic [3:0] prev;
    dev_want = 4'b1111;
    step();
    check4("R2 all request", bus_req, 4'b1111);
    step();
    check4("R3 top wins", bus_master, 4'b1000);
    check4("R3 others wait", bus_req, 4'b0111);
    prev = bus_master;
    for (int k = 0; k < 6; k++) begin
      step();
      check4("R6 turn taking", bus_master, (prev == 4'b1000) ? 4'b0100 : 4'b1000);
      check4("R6 no repeat", bus_master & prev, 4'b0000);
      check4("R8 low devices starve", bus_req & 4'b0011, 4'b0011);
      check4("R5 rerequest after own", bus_req & 4'b1100, (prev == 4'b1000) ? 4'b1000 : 4'b0100);
      prev = bus_master;
    end
    // now prev == 1000 (even number of steps); drop all wants
    dev_want = 4'b0000;
    step();
    check4("R9 drain dev2", bus_master, 4'b0100);
    check4("R5 R9 drain req", bus_req, 4'b0011);
    step();
    check4("R3 drain dev1", bus_master, 4'b0010);
    check4("R9 drain req2", bus_req, 4'b0001);
    step();
    check4("R3 drain dev0", bus_master, 4'b0001);
    check4("R4 drain req3", bus_req, 4'b0000);
    step();
    check4("R5 all idle", bus_master | bus_req, 4'b0000);
  endtask

  task automatic t_pair();
    dev_want = 4'b0101;
    step();
    check4("R2 pair req", bus_req, 4'b0101);
    step();
    check4("R3 pair higher wins", bus_master, 4'b0100);
    step();
    check4("R6 pair lower gets turn", bus_master, 4'b0001);
    check4("R5 pair rerequest", bus_req, 4'b0100);
    dev_want = 4'b0000;
    step();
    check4("R7 pair single owner", bus_master, 4'b0100);
    step();
    step();
    check4("R5 pair idle", bus_master | bus_req, 4'b0000);
  endtask

  initial begin
    step();
    t_reset();
    t_single();
    t_contend();
    t_pair();
    t_reset();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

endmodule